// File: doc/BRIEF.md
# GPIO Port Register Bank

This block is the software-visible register file of a 32-pin general purpose I/O port. A simple word-wide bus writes and reads the output latch, the direction register and one configuration word per pin. The output and direction registers can each be written three ways: the plain write replaces the register, the set form ORs the written bits in, and the clear form removes them.

The direction of each pin is visible in two places: in the direction register and in bit 0 of that pin's configuration word. The bank keeps both views equal whichever one software writes. The input register holds the resolved pin levels. The pin-resolution logic beside this block supplies them, and they are read-only here. The current output, direction and configuration values are driven out continuously to that pin logic.

Bus reads are combinational. While `bus_sel` is high, `bus_rdata` and `bus_err` reflect the register state before the clock edge. Writes take effect at that edge.

Top module: `gpio_regbank`

## Requirements
- R1: A write to 0x504 replaces the output latch. A write to 0x508 ORs the data into it. A write to 0x50C clears every latch bit that is 1 in the data.
- R2: The direction register takes the same three forms: replace at 0x514, set at 0x518, clear at 0x51C.
- R3: After any write to 0x514, 0x518 or 0x51C, bit 0 of each pin's configuration word equals that pin's new direction bit. Bits 31:1 of every configuration word are unchanged.
- R4: A write to 0x700 + 4*k stores all 32 bits as pin k's configuration word. The same write sets direction bit k to data bit 0 and leaves the other direction bits alone.
- R5: Reads return the output latch at 0x504, 0x508 and 0x50C, the direction register at 0x514, 0x518 and 0x51C, and pin k's configuration word at 0x700 + 4*k, with 0 <= k < 32.
- R6: A read at 0x510 returns `pin_in` as it was at the previous clock edge. Writes to 0x510 change no state.
- R7: Synchronous reset clears the output, input and direction registers to 0. It sets every configuration word to 0x00000002.
- R8: An access to any other offset raises `bus_err` in the same cycle, reads as 0 and changes no state. Other offsets include offsets with bits 1:0 not zero, such as 0x502. `bus_err` is 0 for every mapped offset.
- R9: `gpio_out` and `gpio_dir` always equal the output latch and the direction register. Bits 32*k+31 to 32*k of `pin_cfg` always hold pin k's configuration word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when idle or unmapped |
| bus_err | output | 1 | Unmapped offset response |
| pin_in | input | 32 | Resolved pin levels from the pin logic |
| gpio_out | output | 32 | Output latch |
| gpio_dir | output | 32 | Direction register, 1 = output |
| pin_cfg | output | 1024 | All configuration words, pin k in bits 32*k+31 to 32*k |

## Verification
Directed writes use distinct patterns for the replace, set and clear forms. Alternating nibbles, single bytes and a single low bit show whether each form ORs, clears or replaces. The mirror is exercised from both sides. A configuration word with rich upper bits and bit 0 clear is written first, then the direction is set through its alias. This shows whether the upper bits survive and bit 0 follows. Several thousand random accesses then mix all aliases, configuration indices, misaligned and out-of-range offsets and changing pin levels. Every cycle compares the read data, the error flag and all exported state against a behavioural model.

// File: rtl/gpio_regs_pkg.sv
package gpio_regs_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 12;
    localparam int unsigned IDX_W  = 5;

    localparam logic [ADDR_W-1:0] OFF_OUT     = 12'h504;
    localparam logic [ADDR_W-1:0] OFF_OUT_SET = 12'h508;
    localparam logic [ADDR_W-1:0] OFF_OUT_CLR = 12'h50C;
    localparam logic [ADDR_W-1:0] OFF_IN      = 12'h510;
    localparam logic [ADDR_W-1:0] OFF_DIR     = 12'h514;
    localparam logic [ADDR_W-1:0] OFF_DIR_SET = 12'h518;
    localparam logic [ADDR_W-1:0] OFF_DIR_CLR = 12'h51C;
    localparam logic [ADDR_W-1:0] OFF_CFG0    = 12'h700;

    localparam logic [DATA_W-1:0] CFG_RST = 32'h0000_0002;

    typedef enum logic [2:0] {
        TGT_NONE = 3'd0,
        TGT_OUT  = 3'd1,
        TGT_IN   = 3'd2,
        TGT_DIR  = 3'd3,
        TGT_CFG  = 3'd4
    } tgt_e;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_SET  = 2'd1,
        OP_CLR  = 2'd2
    } wop_e;

    typedef struct packed {
        tgt_e             tgt;
        wop_e             op;
        logic [IDX_W-1:0] idx;
    } dec_t;

    function automatic logic [DATA_W-1:0] apply_op(
        input wop_e              op,
        input logic [DATA_W-1:0] old_v,
        input logic [DATA_W-1:0] wd
    );
        case (op)
            OP_SET:  apply_op = old_v | wd;
            OP_CLR:  apply_op = old_v & ~wd;
            default: apply_op = wd;
        endcase
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_regs_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam logic [ADDR_W-3:0] NWORDS = (ADDR_W-2)'(NPINS);

    logic [ADDR_W-3:0] wrel;

    always_comb begin
        wrel = addr[ADDR_W-1:2] - OFF_CFG0[ADDR_W-1:2];
        dec  = '0;
        case (addr)
            OFF_OUT:     begin dec.tgt = TGT_OUT; dec.op = OP_LOAD; end
            OFF_OUT_SET: begin dec.tgt = TGT_OUT; dec.op = OP_SET;  end
            OFF_OUT_CLR: begin dec.tgt = TGT_OUT; dec.op = OP_CLR;  end
            OFF_IN:      begin dec.tgt = TGT_IN;  dec.op = OP_LOAD; end
            OFF_DIR:     begin dec.tgt = TGT_DIR; dec.op = OP_LOAD; end
            OFF_DIR_SET: begin dec.tgt = TGT_DIR; dec.op = OP_SET;  end
            OFF_DIR_CLR: begin dec.tgt = TGT_DIR; dec.op = OP_CLR;  end
            default: begin
                if (addr[1:0] == 2'b00 && addr >= OFF_CFG0 && wrel < NWORDS) begin
                    dec.tgt = TGT_CFG;
                    dec.op  = OP_LOAD;
                    dec.idx = wrel[IDX_W-1:0];
                end
            end
        endcase
    end
endmodule

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
    import gpio_regs_pkg::*;
#(
    parameter int unsigned W   = 32,
    parameter int unsigned IW  = (W > 1) ? $clog2(W) : 1,
    parameter logic [W-1:0] RST = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  wop_e              op,
    input  logic [DATA_W-1:0] wdata,
    input  logic              bit_en,
    input  logic [IW-1:0]     bit_idx,
    input  logic              bit_val,
    output logic [W-1:0]      q
);
    logic [DATA_W-1:0] next_full;

    always_comb next_full = apply_op(op, DATA_W'(q), wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RST;
        end else if (wr_en) begin
            q <= next_full[W-1:0];
        end else if (bit_en) begin
            q[bit_idx] <= bit_val;
        end
    end

    // R1 / R2: the three write forms
    a_r1_load_replaces: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op == OP_LOAD) |=> q == $past(wdata[W-1:0]));
    a_r1_set_ors: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op == OP_SET) |=> q == ($past(q) | $past(wdata[W-1:0])));
    a_r2_clr_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op == OP_CLR) |=> q == ($past(q) & ~$past(wdata[W-1:0])));
    a_r8_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !bit_en) |=> $stable(q));
endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
    import gpio_regs_pkg::*;
#(
    parameter int unsigned NPINS = 32,
    parameter int unsigned IW    = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               wr_en,
    input  logic [IW-1:0]                      idx,
    input  logic [DATA_W-1:1]                  wdata_hi,
    output logic [NPINS-1:0][DATA_W-1:1]       cfg_hi
);
    // Bit 0 of each word lives in the direction register; only 31:1 are stored here.
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_hi[i] <= CFG_RST[DATA_W-1:1];
            end else if (wr_en && idx == IW'(i)) begin
                cfg_hi[i] <= wdata_hi;
            end
        end

        // R3 / R4: only an addressed configuration write moves the upper bits
        a_r3_upper_bits_hold: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && idx == IW'(i)) |=> $stable(cfg_hi[i]));
        a_r4_word_stored: assert property (@(posedge clk) disable iff (rst)
            (wr_en && idx == IW'(i)) |=> cfg_hi[i] == $past(wdata_hi));
    end
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
    import gpio_regs_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bus_sel,
    input  logic                    bus_we,
    input  logic [11:0]             bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    output logic                    bus_err,
    input  logic [NPINS-1:0]        pin_in,
    output logic [NPINS-1:0]        gpio_out,
    output logic [NPINS-1:0]        gpio_dir,
    output logic [NPINS*32-1:0]     pin_cfg
);
    localparam int unsigned IW = (NPINS > 1) ? $clog2(NPINS) : 1;

    dec_t                          dec;
    logic                          wr;
    logic [NPINS-1:0]              out_q;
    logic [NPINS-1:0]              dir_q;
    logic [NPINS-1:0]              in_q;
    logic [NPINS-1:0][DATA_W-1:1]  cfg_hi;
    logic [IW-1:0]                 pin_idx;
    logic [DATA_W-1:0]             rd_val;

    gpio_addr_decode #(.NPINS(NPINS)) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    assign wr      = bus_sel && bus_we;
    assign pin_idx = dec.idx[IW-1:0];

    gpio_alias_reg #(.W(NPINS)) u_out (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr && dec.tgt == TGT_OUT),
        .op      (dec.op),
        .wdata   (bus_wdata),
        .bit_en  (1'b0),
        .bit_idx ('0),
        .bit_val (1'b0),
        .q       (out_q)
    );

    gpio_alias_reg #(.W(NPINS)) u_dir (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr && dec.tgt == TGT_DIR),
        .op      (dec.op),
        .wdata   (bus_wdata),
        .bit_en  (wr && dec.tgt == TGT_CFG),
        .bit_idx (pin_idx),
        .bit_val (bus_wdata[0]),
        .q       (dir_q)
    );

    gpio_cfg_bank #(.NPINS(NPINS)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr && dec.tgt == TGT_CFG),
        .idx      (pin_idx),
        .wdata_hi (bus_wdata[DATA_W-1:1]),
        .cfg_hi   (cfg_hi)
    );

    always_ff @(posedge clk) begin
        if (rst) in_q <= '0;
        else     in_q <= pin_in;
    end

    always_comb begin
        case (dec.tgt)
            TGT_OUT: rd_val = DATA_W'(out_q);
            TGT_IN:  rd_val = DATA_W'(in_q);
            TGT_DIR: rd_val = DATA_W'(dir_q);
            TGT_CFG: rd_val = {cfg_hi[pin_idx], dir_q[pin_idx]};
            default: rd_val = '0;
        endcase
    end

    assign bus_rdata = bus_sel ? rd_val : '0;
    assign bus_err   = bus_sel && dec.tgt == TGT_NONE;
    assign gpio_out  = out_q;
    assign gpio_dir  = dir_q;

    for (genvar i = 0; i < NPINS; i++) begin : g_cfg_out
        assign pin_cfg[i*32 +: 32] = {cfg_hi[i], dir_q[i]};
    end

    // R8: unmapped accesses leave every register alone
    a_r8_err_no_change: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_err) |=> $stable(gpio_out) && $stable(gpio_dir) && $stable(pin_cfg));
    // R6: writes to the input register are ignored
    a_r6_in_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr && dec.tgt == TGT_IN) |=> $stable(gpio_out) && $stable(gpio_dir) && $stable(pin_cfg));
    // R4: a configuration write moves the matching direction bit
    a_r4_cfg_to_dir: assert property (@(posedge clk) disable iff (rst)
        (wr && dec.tgt == TGT_CFG) |=> gpio_dir[$past(pin_idx)] == $past(bus_wdata[0]));
    // R7: state right after reset
    a_r7_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (gpio_out == '0 && gpio_dir == '0 && in_q == '0));
endmodule

// File: tb/gpio_regbank_tb_top.sv
`timescale 1ns/1ps
module gpio_regbank_tb_top;

    logic          clk = 1'b0;
    logic          rst;
    logic          bus_sel;
    logic          bus_we;
    logic [11:0]   bus_addr;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata;
    logic          bus_err;
    logic [31:0]   pin_in;
    logic [31:0]   gpio_out;
    logic [31:0]   gpio_dir;
    logic [1023:0] pin_cfg;

    int vectors = 0;
    int miscompares = 0;

    // behavioural model
    logic [31:0] m_out, m_dir, m_in;
    logic [31:0] m_cfg [32];

    always #2 clk = ~clk;

    gpio_regbank dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err),
        .pin_in    (pin_in),
        .gpio_out  (gpio_out),
        .gpio_dir  (gpio_dir),
        .pin_cfg   (pin_cfg)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit is_mapped(input logic [11:0] a);
        if (a == 12'h504 || a == 12'h508 || a == 12'h50C || a == 12'h510 ||
            a == 12'h514 || a == 12'h518 || a == 12'h51C) return 1'b1;
        return (a[1:0] == 2'b00 && a >= 12'h700 && a <= 12'h77C);
    endfunction

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        if (!is_mapped(a)) return 32'h0;
        if (a == 12'h504 || a == 12'h508 || a == 12'h50C) return m_out;
        if (a == 12'h510) return m_in;
        if (a == 12'h514 || a == 12'h518 || a == 12'h51C) return m_dir;
        return m_cfg[(a - 12'h700) >> 2];
    endfunction

    task automatic model_reset();
        m_out = 0; m_dir = 0; m_in = 0;
        for (int i = 0; i < 32; i++) m_cfg[i] = 32'h2;
    endtask

    task automatic model_write(input logic [11:0] a, input logic [31:0] d);
        int k;
        bit dir_touched = 0;
        case (a)
            12'h504: m_out = d;
            12'h508: m_out = m_out | d;
            12'h50C: m_out = m_out & ~d;
            12'h514: begin m_dir = d;          dir_touched = 1; end
            12'h518: begin m_dir = m_dir | d;  dir_touched = 1; end
            12'h51C: begin m_dir = m_dir & ~d; dir_touched = 1; end
            default: begin
                if (is_mapped(a) && a >= 12'h700) begin
                    k = int'((a - 12'h700) >> 2);
                    m_cfg[k] = d;
                    m_dir[k] = d[0];
                end
            end
        endcase
        if (dir_touched)
            for (int i = 0; i < 32; i++) m_cfg[i][0] = m_dir[i];
    endtask

    // One bus cycle: drive, compare before the edge, then advance the model.
    task automatic access(input bit we, input logic [11:0] a, input logic [31:0] d,
                          input logic [31:0] pins, input string tag);
        int bad;
        @(negedge clk);
        bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d; pin_in = pins;
        #1;
        chk(tag, bus_rdata, exp_read(a));
        chk("R8 err", {31'b0, bus_err}, {31'b0, !is_mapped(a)});
        chk("R9 gpio_out", gpio_out, m_out);
        chk("R9 gpio_dir", gpio_dir, m_dir);
        bad = 0;
        for (int i = 0; i < 32; i++) if (pin_cfg[i*32 +: 32] !== m_cfg[i]) bad++;
        chk("R9 pin_cfg mismatching words", bad, 0);
        @(posedge clk);
        if (we) model_write(a, d);
        m_in = pins;
    endtask

    function automatic logic [11:0] pick_addr();
        logic [11:0] bad_list [6] = '{12'h500, 12'h520, 12'h780, 12'h502, 12'h6FC, 12'h707};
        int r = $urandom_range(0, 10);
        case (r)
            0: return 12'h504;
            1: return 12'h508;
            2: return 12'h50C;
            3: return 12'h510;
            4: return 12'h514;
            5: return 12'h518;
            6: return 12'h51C;
            7, 8: return 12'h700 + 12'($urandom_range(0, 31) * 4);
            9: return 12'h77C;
            default: return bad_list[$urandom_range(0, 5)];
        endcase
    endfunction

    initial begin
        #(4ns * 200000);
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0; pin_in = 0;
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R7: reset values
        access(0, 12'h504, 0, 32'h0, "R7 out");
        access(0, 12'h510, 0, 32'h0, "R7 in");
        access(0, 12'h514, 0, 32'h0, "R7 dir");
        access(0, 12'h700, 0, 32'h0, "R7 cfg0");
        access(0, 12'h77C, 0, 32'h0, "R7 cfg31");

        // R1: output write forms; R5 alias readback
        access(1, 12'h504, 32'hA5A5_A5A5, 0, "R1 load");
        access(0, 12'h504, 0, 0, "R1 after load");
        access(1, 12'h508, 32'h0F0F_0000, 0, "R1 set");
        access(0, 12'h50C, 0, 0, "R5 out via clear alias");
        access(1, 12'h50C, 32'h0000_0005, 0, "R1 clear");
        access(0, 12'h508, 0, 0, "R5 out via set alias");

        // R2: direction write forms
        access(1, 12'h514, 32'h0000_FF00, 0, "R2 load");
        access(1, 12'h518, 32'h8000_0001, 0, "R2 set");
        access(1, 12'h51C, 32'h0000_0F00, 0, "R2 clear");
        access(0, 12'h518, 0, 0, "R5 dir via set alias");
        access(0, 12'h51C, 0, 0, "R5 dir via clear alias");

        // R3: direction set reaches cfg bit 0, upper bits kept
        access(1, 12'h724, 32'h0003_0C0E, 0, "R3 cfg9 write");
        access(1, 12'h518, 32'h0000_0200, 0, "R3 dir set pin9");
        access(0, 12'h724, 0, 0, "R3 cfg9 bit0 follows dir");
        access(1, 12'h51C, 32'h0000_0200, 0, "R3 dir clr pin9");
        access(0, 12'h724, 0, 0, "R3 cfg9 bit0 cleared");

        // R4: cfg write moves one direction bit
        access(1, 12'h750, 32'hDEAD_BEEF, 0, "R4 cfg20 write");
        access(0, 12'h514, 0, 0, "R4 dir bit20");
        access(0, 12'h750, 0, 0, "R4 cfg20 readback");

        // R6: input register sampling, writes ignored
        access(0, 12'h504, 0, 32'h1234_5678, "R6 present pins");
        access(0, 12'h510, 0, 32'h1234_5678, "R6 in sampled");
        access(1, 12'h510, 32'hFFFF_FFFF, 32'h0BAD_F00D, "R6 write ignored");
        access(0, 12'h510, 0, 32'h0BAD_F00D, "R6 in after write");

        // R8: unmapped and misaligned
        access(1, 12'h520, 32'hFFFF_FFFF, 0, "R8 write unmapped");
        access(1, 12'h502, 32'hFFFF_FFFF, 0, "R8 write misaligned");
        access(1, 12'h780, 32'hFFFF_FFFF, 0, "R8 write past cfg");
        access(0, 12'h6FC, 0, 0, "R8 read below cfg");
        access(0, 12'h504, 0, 0, "R8 out unchanged");

        // R5/R9: random mix
        for (int n = 0; n < 3000; n++) begin
            access(1'($urandom_range(0, 1)), pick_addr(), $urandom(), $urandom(), "R5 random");
        end

        @(negedge clk); bus_sel = 0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule